// File: doc/BRIEF.md
# One-Wire Slave Bit-Slot Responder

This block is the device end of a single-wire, open-drain bus. It watches the bus level and controls one active-low pulldown enable. Every exchange on the bus starts when the master pulls the line low. The block brings that input through a two-flop synchroniser and finds falling edges on the clean copy. Each falling edge starts a one-shot delay. In a write slot, the block samples the line once, when that delay runs out, and reports the bit on a one-cycle strobe. In a read slot with a 0 to send, it holds the line low for the length of the delay. This overrides the high level the master leaves after its short start pulse. In a read slot with a 1 to send, it does not touch the line.

A separate meter measures how long the line stays low. A low long enough to count as a bus reset cancels any slot in progress and releases the line. When the master lets the line rise, the block waits a short fixed time and then answers with a presence low of fixed length. The surrounding logic sets the mode input to choose read or write for the next slot, and sets the bit to send. Command decoding and any storage are left to that logic.

Top module: `owire_slot_slave`

## Requirements
- R1: After reset, `bus_pull_n` is 1 (line released) and `rx_valid` is 0.
- R2: In write mode (`mode_read`=0), a falling edge on the bus produces exactly one `rx_valid` pulse, one cycle wide. The pulse comes SAMPLE_CYC cycles after the synchronised edge is seen, which is SAMPLE_CYC+2 to SAMPLE_CYC+4 clock edges after the bus goes low.
- R3: `rx_bit` with the strobe equals the bus level at the sample point: 1 if the master released the line before then, 0 if the line was still low.
- R4: In read mode (`mode_read`=1) with `tx_bit`=0, `bus_pull_n` goes to 0 for exactly HOLD_CYC cycles from the detected edge, so the bus reads 0 after the master releases it.
- R5: In read mode with `tx_bit`=1, `bus_pull_n` stays 1 for the whole slot, so the bus reads 1.
- R6: A low lasting RST_CYC cycles or more is a bus reset. After the master releases the line, `bus_pull_n` goes to 0 PRES_WAIT_CYC cycles after the synchronised rise (PRES_WAIT_CYC+2 to PRES_WAIT_CYC+4 edges after the release) and stays 0 for exactly PRES_LOW_CYC cycles.
- R7: A low shorter than RST_CYC cycles produces no presence pulse.
- R8: A reset low that begins as a slot cancels that slot. The line stays released for the rest of the reset low, and the presence sequence of R6 still follows.
- R9: Read-mode slots never raise `rx_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_in | input | 1 | Raw bus level, asynchronous to clk |
| mode_read | input | 1 | 1: the next slot sends a bit; 0: the next slot receives a bit |
| tx_bit | input | 1 | Bit to send in a read slot |
| bus_pull_n | output | 1 | Active-low pulldown enable (0 pulls the line low) |
| rx_valid | output | 1 | One-cycle strobe carrying a received write bit |
| rx_bit | output | 1 | Received write bit, valid with rx_valid |

## Verification
The hardest case to reach from the ports is a reset low that starts out as an ordinary slot. In that case the slot logic has already begun to act before the low-time meter reaches its limit. The bench sets read mode with a 0 to send and then keeps the master low past the reset threshold. This makes the block first pull the line itself and then give it up, and the bench confirms that the line stays released until the master lets go and that the presence pulse follows. The bench models the bus as a wired-AND of master and slave, so every check observes the bus as a real master would.

// File: rtl/ow_pkg.sv
package ow_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WSLOT,
    ST_RHOLD,
    ST_RSTLOW,
    ST_PWAIT,
    ST_PLOW
  } ow_state_e;

  function automatic int unsigned ow_max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic int unsigned ow_bits_for(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

  function automatic bit ow_drives_low(input ow_state_e s);
    return (s == ST_RHOLD) || (s == ST_PLOW);
  endfunction

endpackage

// File: rtl/ow_sync_edge.sv
module ow_sync_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_async,
  output logic line,
  output logic fell,
  output logic rose
);
  logic meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b1;
      sync_q <= 1'b1;
      prev_q <= 1'b1;
    end else begin
      meta_q <= bus_async;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign line = sync_q;
  assign fell = prev_q & ~sync_q;
  assign rose = ~prev_q & sync_q;
endmodule

// File: rtl/ow_low_meter.sv
module ow_low_meter #(
  parameter int unsigned LIMIT = 24000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line,
  output logic long_low
);
  localparam int unsigned LW = ow_pkg::ow_bits_for(LIMIT);
  localparam logic [LW-1:0] LIM = LW'(LIMIT);

  logic [LW-1:0] low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            low_cnt <= '0;
    else if (line)         low_cnt <= '0;
    else if (low_cnt != LIM) low_cnt <= low_cnt + 1'b1;
  end

  assign long_low = (low_cnt == LIM);
endmodule

// File: rtl/ow_oneshot.sv
module ow_oneshot #(
  parameter int unsigned TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          expire
);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign expire = (cnt == TW'(1));
endmodule

// File: rtl/owire_slot_slave.sv
module owire_slot_slave #(
  parameter int unsigned SAMPLE_CYC    = 1500,
  parameter int unsigned HOLD_CYC      = 1500,
  parameter int unsigned RST_CYC       = 24000,
  parameter int unsigned PRES_WAIT_CYC = 1500,
  parameter int unsigned PRES_LOW_CYC  = 6000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_in,
  input  logic mode_read,
  input  logic tx_bit,
  output logic bus_pull_n,
  output logic rx_valid,
  output logic rx_bit
);
  import ow_pkg::*;

  localparam int unsigned MAXT = ow_max2(ow_max2(SAMPLE_CYC, HOLD_CYC),
                                         ow_max2(PRES_WAIT_CYC, PRES_LOW_CYC));
  localparam int unsigned TW = ow_bits_for(MAXT);

  ow_state_e st, st_n;
  logic line, line_fell, line_rose, long_low, expire;
  logic ld, rxv_n;
  logic [TW-1:0] ldv;

  // named events for the checker
  logic slot_fall, rst_enter, pres_start;

  ow_sync_edge u_sync (
    .clk(clk), .rst_n(rst_n), .bus_async(bus_in),
    .line(line), .fell(line_fell), .rose(line_rose)
  );

  ow_low_meter #(.LIMIT(RST_CYC)) u_meter (
    .clk(clk), .rst_n(rst_n), .line(line), .long_low(long_low)
  );

  ow_oneshot #(.TW(TW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(ld), .load_val(ldv), .expire(expire)
  );

  assign rst_enter  = long_low && (st != ST_RSTLOW);
  assign slot_fall  = (st == ST_IDLE) && line_fell && !rst_enter;
  assign pres_start = (st == ST_PWAIT) && expire && !rst_enter;

  always_comb begin
    st_n  = st;
    ld    = 1'b0;
    ldv   = '0;
    rxv_n = 1'b0;
    if (rst_enter) begin
      st_n = ST_RSTLOW;
    end else begin
      case (st)
        ST_IDLE: begin
          if (line_fell) begin
            if (!mode_read) begin
              st_n = ST_WSLOT;
              ld   = 1'b1;
              ldv  = TW'(SAMPLE_CYC);
            end else if (!tx_bit) begin
              st_n = ST_RHOLD;
              ld   = 1'b1;
              ldv  = TW'(HOLD_CYC);
            end
          end
        end
        ST_WSLOT: begin
          if (expire) begin
            st_n  = ST_IDLE;
            rxv_n = 1'b1;
          end
        end
        ST_RHOLD: begin
          if (expire) st_n = ST_IDLE;
        end
        ST_RSTLOW: begin
          if (line_rose) begin
            st_n = ST_PWAIT;
            ld   = 1'b1;
            ldv  = TW'(PRES_WAIT_CYC);
          end
        end
        ST_PWAIT: begin
          if (expire) begin
            st_n = ST_PLOW;
            ld   = 1'b1;
            ldv  = TW'(PRES_LOW_CYC);
          end
        end
        ST_PLOW: begin
          if (expire) st_n = ST_IDLE;
        end
        default: st_n = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      rx_valid <= 1'b0;
      rx_bit   <= 1'b0;
    end else begin
      st       <= st_n;
      rx_valid <= rxv_n;
      if (rxv_n) rx_bit <= line;
    end
  end

  assign bus_pull_n = !ow_drives_low(st);
endmodule

// File: rtl/ow_slot_checker.sv
module ow_slot_checker (
  input logic clk,
  input logic rst_n,
  input logic bus_pull_n,
  input logic rx_valid,
  input logic mode_read,
  input logic tx_bit,
  input logic slot_fall,
  input logic rst_enter,
  input logic pres_start
);
  AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) rx_valid |=> !rx_valid); // R2
  AST_READ0_PULLS: assert property (@(posedge clk) disable iff (!rst_n) (slot_fall && mode_read && !tx_bit) |=> !bus_pull_n); // R4
  AST_READ1_SILENT: assert property (@(posedge clk) disable iff (!rst_n) (slot_fall && mode_read && tx_bit) |=> bus_pull_n); // R5
  AST_PRESENCE_BEGINS: assert property (@(posedge clk) disable iff (!rst_n) pres_start |=> !bus_pull_n); // R6
  AST_RESET_RELEASES: assert property (@(posedge clk) disable iff (!rst_n) rst_enter |=> bus_pull_n); // R8
  AST_PULL_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) $fell(bus_pull_n) |-> ($past(slot_fall) || $past(pres_start))); // R4
  AST_READ_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n) (slot_fall && mode_read) |=> !rx_valid); // R9
endmodule

bind owire_slot_slave ow_slot_checker u_chk (
  .clk(clk), .rst_n(rst_n), .bus_pull_n(bus_pull_n), .rx_valid(rx_valid),
  .mode_read(mode_read), .tx_bit(tx_bit), .slot_fall(slot_fall),
  .rst_enter(rst_enter), .pres_start(pres_start)
);

// File: tb/sim_owire_slot_slave.sv
`timescale 1ns/1ps
module sim_owire_slot_slave;
  localparam int S   = 30;
  localparam int H   = 30;
  localparam int RST = 480;
  localparam int PW  = 30;
  localparam int PL  = 120;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_low = 1'b0;
  logic mode_read = 1'b0;
  logic tx_bit = 1'b1;
  logic bus_pull_n, rx_valid, rx_bit;
  logic bus;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  assign bus = (m_low || !bus_pull_n) ? 1'b0 : 1'b1;

  always #10 clk = ~clk;

  owire_slot_slave #(.SAMPLE_CYC(S), .HOLD_CYC(H), .RST_CYC(RST),
                     .PRES_WAIT_CYC(PW), .PRES_LOW_CYC(PL)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_in(bus), .mode_read(mode_read),
    .tx_bit(tx_bit), .bus_pull_n(bus_pull_n), .rx_valid(rx_valid), .rx_bit(rx_bit)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic t_reset_state();
    @(negedge clk);
    chk(bus_pull_n == 1'b1, "R1 line released", int'(bus_pull_n), 1);
    chk(rx_valid == 1'b0, "R1 no strobe", int'(rx_valid), 0);
  endtask

  task automatic t_write(input bit val);
    int strobes = 0;
    int when = -1;
    int got = -1;
    int low_len = val ? 6 : 60;
    @(negedge clk);
    mode_read = 1'b0;
    m_low = 1'b1;
    for (int c = 1; c <= 100; c++) begin
      @(negedge clk);
      if (c == low_len) m_low = 1'b0;
      if (rx_valid) begin
        strobes++;
        if (when < 0) begin when = c; got = int'(rx_bit); end
      end
    end
    chk(strobes == 1, "R2 strobe count", strobes, 1);
    chk(when >= S + 2 && when <= S + 4, "R2 strobe latency", when, S + 3);
    chk(got == int'(val), "R3 received bit", got, int'(val));
  endtask

  task automatic t_read(input bit val);
    int pulls = 0;
    int strobes = 0;
    int seen = -1;
    @(negedge clk);
    mode_read = 1'b1;
    tx_bit = val;
    m_low = 1'b1;
    for (int c = 1; c <= 100; c++) begin
      @(negedge clk);
      if (c == 2) m_low = 1'b0;
      if (!bus_pull_n) pulls++;
      if (rx_valid) strobes++;
      if (c == 15) seen = int'(bus);
    end
    if (val) chk(pulls == 0, "R5 no drive for a 1", pulls, 0);
    else     chk(pulls == H, "R4 hold length for a 0", pulls, H);
    chk(seen == int'(val), val ? "R5 bus reads 1" : "R4 bus reads 0", seen, int'(val));
    chk(strobes == 0, "R9 no strobe in read mode", strobes, 0);
    mode_read = 1'b0;
    tx_bit = 1'b1;
  endtask

  task automatic t_bus_reset(input bit from_read0);
    int late_pulls = 0;
    int start = -1;
    int len = 0;
    @(negedge clk);
    mode_read = from_read0;
    tx_bit = !from_read0;
    m_low = 1'b1;
    for (int c = 1; c <= RST + 20; c++) begin
      @(negedge clk);
      if (c > H + 10 && !bus_pull_n) late_pulls++;
    end
    m_low = 1'b0;
    for (int c = 1; c <= PW + PL + 40; c++) begin
      @(negedge clk);
      if (!bus_pull_n) begin
        if (start < 0) start = c;
        len++;
      end
    end
    if (from_read0) chk(late_pulls == 0, "R8 line released during reset", late_pulls, 0);
    else            chk(late_pulls == 0, "R6 no drive before release", late_pulls, 0);
    chk(start >= PW + 2 && start <= PW + 4, from_read0 ? "R8 presence delay" : "R6 presence delay", start, PW + 3);
    chk(len == PL, from_read0 ? "R8 presence length" : "R6 presence length", len, PL);
    mode_read = 1'b0;
    tx_bit = 1'b1;
  endtask

  task automatic t_short_low();
    int pulls = 0;
    @(negedge clk);
    mode_read = 1'b1;
    tx_bit = 1'b1;
    m_low = 1'b1;
    for (int c = 1; c <= RST + 260; c++) begin
      @(negedge clk);
      if (c == RST - 40) m_low = 1'b0;
      if (!bus_pull_n) pulls++;
    end
    chk(pulls == 0, "R7 no presence after short low", pulls, 0);
    mode_read = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset_state();
    idle(5);
    t_write(1'b1);  idle(10);
    t_write(1'b0);  idle(10);
    t_read(1'b0);   idle(10);
    t_read(1'b1);   idle(10);
    t_bus_reset(1'b0); idle(10);
    t_bus_reset(1'b1); idle(10);
    t_short_low();  idle(10);
    t_write(1'b0);  idle(10);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule